// File: doc/BRIEF.md
# Vector Element Issue Sequencer

This block turns one decoded scalar-format instruction into a series of per-element operations whenever any of its register operands carries a vector tag. A 32-entry tag table, written through a plain write port, holds for each architectural register a vector flag, a target register in a 128-entry physical file and an element-width code. When an instruction is accepted, the block looks up all three operands in the table and keeps those descriptors. It then steps through element slots 0 to vector-length minus 1. Each slot whose predicate bit is set produces one operation carrying redirected register numbers, byte offsets and element widths. A slot whose predicate bit is clear produces nothing.

Instructions enter through a valid/ready handshake (`in_valid`/`in_ready`). Element operations leave through a second valid/ready handshake (`out_valid`/`out_ready`). While an instruction is being expanded, `in_ready` stays low. When `out_valid` is high and `out_ready` is low, every output field stays unchanged until the transfer completes. The element counter moves on only after a completed output transfer or a skipped slot, so at most one operation leaves per cycle. A synchronous `flush` drops the instruction in progress. This is used for exception or mispredict rollback.

Top module: `vec_elem_seq`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: For an instruction with at least one tagged operand, one operation is emitted for each enabled element, in increasing element order. `out_elem` carries the element index.
- R3: An element whose bit in `in_pred` (bit i for element i) is 0 emits no operation. The next enabled element follows directly.
- R4: For a tagged operand with target T and width W bits, element i uses register (T + floor(i*W/64)) mod 128. Untagged operands use their architectural number, zero-extended to 7 bits.
- R5: The width code is 0=64, 1=32, 2=16, 3=8 bits. It is output per operand as `*_ew`. The byte offset is ((i*W) mod 64)/8.
- R6: Two architectural registers tagged to the same target with different widths are each resolved with their own width.
- R7: Untagged operands are repeated unchanged in every element operation, with offset 0 and width code 0.
- R8: If no operand is tagged, exactly one operation is emitted with element index 0. This holds whatever the values of `in_vlen` and `in_pred`.
- R9: A tagged instruction with `in_vlen` of 0, or with no enabled element below `in_vlen`, emits nothing. The block then accepts a new instruction again.
- R10: While `out_valid` is 1, `in_ready` is 0. While `out_valid` is 1 and `out_ready` is 0, all output fields hold their values into the next cycle.
- R11: In the cycle after `flush` is 1, `out_valid` is 0 and `in_ready` is 1. The dropped instruction emits nothing further.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop the instruction in progress |
| tag_we | input | 1 | Tag table write enable |
| tag_waddr | input | 5 | Architectural register whose tag is written |
| tag_wvec | input | 1 | Vector flag to write |
| tag_wtarget | input | 7 | Target physical register to write |
| tag_wew | input | 2 | Element-width code to write |
| in_valid | input | 1 | Instruction valid |
| in_ready | output | 1 | Instruction accepted when high with in_valid |
| in_opcode | input | OP_W | Opcode |
| in_rd | input | 5 | Destination architectural register |
| in_rs1 | input | 5 | First source architectural register |
| in_rs2 | input | 5 | Second source architectural register |
| in_vlen | input | clog2(MAX_VL+1) | Vector length |
| in_pred | input | MAX_VL | Predicate mask, bit i enables element i |
| out_valid | output | 1 | Element operation valid |
| out_ready | input | 1 | Issue queue can take an operation |
| out_opcode | output | OP_W | Opcode copied from the instruction |
| out_elem | output | clog2(MAX_VL) | Element index |
| out_rd | output | 7 | Destination physical register |
| out_rd_off | output | 3 | Destination byte offset |
| out_rd_ew | output | 2 | Destination width code |
| out_rs1 | output | 7 | First source physical register |
| out_rs1_off | output | 3 | First source byte offset |
| out_rs1_ew | output | 2 | First source width code |
| out_rs2 | output | 7 | Second source physical register |
| out_rs2_off | output | 3 | Second source byte offset |
| out_rs2_ew | output | 2 | Second source width code |

## Verification
The first pattern tags only the destination at 32-bit width with every element enabled. It separates the register-step and offset arithmetic from the scalar repetition of the untagged sources. A sparse predicate mask is then combined with all three operands tagged at different widths and an alternating `out_ready`, which shows that slots are skipped correctly while back-pressure holds the output fields steady. Two sources tagged to the same target near the top of the register file, at 8-bit and 32-bit widths, show that width is resolved per operand and that register numbers wrap. An untagged instruction with a large length and an empty mask, tagged instructions with zero length or an all-zero mask, and a flush during an expansion cover the single-operation, empty and rollback paths.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam int AREGS  = 32;
  localparam int PREGS  = 128;
  localparam int AREG_W = $clog2(AREGS);
  localparam int PREG_W = $clog2(PREGS);
  localparam int EW_W   = 2;
  localparam int OFF_W  = 3;
  localparam int NOPND  = 3;

  typedef struct packed {
    logic              vec;
    logic [PREG_W-1:0] tgt;
    logic [EW_W-1:0]   ew;
  } opnd_desc_t;

  typedef struct packed {
    logic [PREG_W-1:0] preg;
    logic [OFF_W-1:0]  off;
    logic [EW_W-1:0]   ew;
  } elem_loc_t;
endpackage

// File: rtl/vseq_tag_table.sv
module vseq_tag_table
  import vseq_pkg::*;
#(
  parameter int NRD = NOPND
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [AREG_W-1:0]           waddr,
  input  logic                        wvec,
  input  logic [PREG_W-1:0]           wtgt,
  input  logic [EW_W-1:0]             wew,
  input  logic [NRD-1:0][AREG_W-1:0]  raddr,
  output opnd_desc_t [NRD-1:0]        rdesc
);
  opnd_desc_t entry_q [AREGS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < AREGS; k++) entry_q[k] <= '0;
    end else if (we) begin
      entry_q[waddr] <= '{vec: wvec, tgt: wtgt, ew: wew};
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (entry_q[raddr[p]].vec) begin
        rdesc[p] = entry_q[raddr[p]];
      end else begin
        rdesc[p].vec = 1'b0;
        rdesc[p].tgt = PREG_W'(raddr[p]);
        rdesc[p].ew  = '0;
      end
    end
  end
endmodule

// File: rtl/vseq_elem_addr.sv
module vseq_elem_addr
  import vseq_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  opnd_desc_t           desc,
  input  logic [IDX_W-1:0]     idx,
  output elem_loc_t            loc
);
  logic [IDX_W-1:0] lane_mask;
  logic [IDX_W-1:0] reg_step;
  logic [IDX_W-1:0] lane;

  always_comb begin
    lane_mask = IDX_W'((1 << desc.ew) - 1);
    reg_step  = idx >> desc.ew;
    lane      = idx & lane_mask;
    if (desc.vec) begin
      loc.preg = desc.tgt + PREG_W'(reg_step);
      loc.off  = OFF_W'(lane << (3 - desc.ew));
      loc.ew   = desc.ew;
    end else begin
      loc.preg = desc.tgt;
      loc.off  = '0;
      loc.ew   = '0;
    end
  end

  // R5
  off_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc.vec |-> ((4'(loc.off) & ((4'd8 >> loc.ew) - 4'd1)) == 4'd0));
endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl #(
  parameter int MAX_VL = 16,
  localparam int VL_W  = $clog2(MAX_VL + 1),
  localparam int IDX_W = $clog2(MAX_VL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  input  logic [VL_W-1:0]   in_vlen,
  input  logic [MAX_VL-1:0] in_pred,
  input  logic              in_vec_any,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              out_valid,
  output logic              load,
  output logic [IDX_W-1:0]  idx
);
  logic              busy_q;
  logic [IDX_W-1:0]  idx_q;
  logic [VL_W-1:0]   vlen_q;
  logic [MAX_VL-1:0] pred_q;
  logic              vec_q;
  logic              slot_on;
  logic              advance;
  logic              at_last;

  assign idx      = idx_q;
  assign slot_on  = !vec_q || pred_q[idx_q];
  assign in_ready = !busy_q && !flush;
  assign load     = in_valid && in_ready;
  assign out_valid = busy_q && slot_on;
  assign advance  = busy_q && (!slot_on || out_ready);
  assign at_last  = vec_q ? (VL_W'(idx_q) == vlen_q - VL_W'(1)) : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      vlen_q <= '0;
      pred_q <= '0;
      vec_q  <= 1'b0;
    end else if (load) begin
      busy_q <= !in_vec_any || (in_vlen != '0);
      idx_q  <= '0;
      vlen_q <= (in_vlen > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : in_vlen;
      pred_q <= in_pred;
      vec_q  <= in_vec_any;
    end else if (advance) begin
      if (at_last) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q  <= idx_q + IDX_W'(1);
      end
    end
  end

  // R9
  empty_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && in_vec_any && in_vlen == '0) |=> !out_valid);

  // R8
  pass_one_chk: assert property (@(posedge clk) disable iff (!rst_n || flush)
    (load && !in_vec_any) |=> out_valid);
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
  import vseq_pkg::*;
#(
  parameter int MAX_VL = 16,
  parameter int OP_W   = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic                          tag_we,
  input  logic [4:0]                    tag_waddr,
  input  logic                          tag_wvec,
  input  logic [6:0]                    tag_wtarget,
  input  logic [1:0]                    tag_wew,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [OP_W-1:0]               in_opcode,
  input  logic [4:0]                    in_rd,
  input  logic [4:0]                    in_rs1,
  input  logic [4:0]                    in_rs2,
  input  logic [$clog2(MAX_VL+1)-1:0]   in_vlen,
  input  logic [MAX_VL-1:0]             in_pred,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [OP_W-1:0]               out_opcode,
  output logic [$clog2(MAX_VL)-1:0]     out_elem,
  output logic [6:0]                    out_rd,
  output logic [2:0]                    out_rd_off,
  output logic [1:0]                    out_rd_ew,
  output logic [6:0]                    out_rs1,
  output logic [2:0]                    out_rs1_off,
  output logic [1:0]                    out_rs1_ew,
  output logic [6:0]                    out_rs2,
  output logic [2:0]                    out_rs2_off,
  output logic [1:0]                    out_rs2_ew
);
  localparam int IDX_W = $clog2(MAX_VL);

  logic [NOPND-1:0][AREG_W-1:0] arch_sel;
  opnd_desc_t [NOPND-1:0]       desc_lk;
  opnd_desc_t [NOPND-1:0]       desc_q;
  elem_loc_t  [NOPND-1:0]       loc;
  logic [OP_W-1:0]              opcode_q;
  logic                         vec_any;
  logic                         load;
  logic [IDX_W-1:0]             idx;

  assign arch_sel[0] = in_rd;
  assign arch_sel[1] = in_rs1;
  assign arch_sel[2] = in_rs2;
  assign vec_any = desc_lk[0].vec || desc_lk[1].vec || desc_lk[2].vec;

  vseq_tag_table #(.NRD(NOPND)) u_tags (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tag_we),
    .waddr (tag_waddr),
    .wvec  (tag_wvec),
    .wtgt  (tag_wtarget),
    .wew   (tag_wew),
    .raddr (arch_sel),
    .rdesc (desc_lk)
  );

  vseq_ctrl #(.MAX_VL(MAX_VL)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .in_valid   (in_valid),
    .in_vlen    (in_vlen),
    .in_pred    (in_pred),
    .in_vec_any (vec_any),
    .out_ready  (out_ready),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .load       (load),
    .idx        (idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      desc_q   <= '0;
      opcode_q <= '0;
    end else if (load) begin
      desc_q   <= desc_lk;
      opcode_q <= in_opcode;
    end
  end

  for (genvar p = 0; p < NOPND; p++) begin : g_opnd
    vseq_elem_addr #(.IDX_W(IDX_W)) u_addr (
      .clk   (clk),
      .rst_n (rst_n),
      .desc  (desc_q[p]),
      .idx   (idx),
      .loc   (loc[p])
    );
  end

  assign out_opcode  = opcode_q;
  assign out_elem    = idx;
  assign out_rd      = loc[0].preg;
  assign out_rd_off  = loc[0].off;
  assign out_rd_ew   = loc[0].ew;
  assign out_rs1     = loc[1].preg;
  assign out_rs1_off = loc[1].off;
  assign out_rs1_ew  = loc[1].ew;
  assign out_rs2     = loc[2].preg;
  assign out_rs2_off = loc[2].off;
  assign out_rs2_ew  = loc[2].ew;

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || flush)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_elem) && $stable(out_rd)
      && $stable(out_rs1) && $stable(out_rs2) && $stable(out_rd_off)
      && $stable(out_rs1_off) && $stable(out_rs2_off) && $stable(out_opcode)));

  // R10
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R11
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!out_valid && in_ready));
endmodule

// File: tb/test_vec_elem_seq.sv
module test_vec_elem_seq;
  localparam int MAX_VL = 16;
  localparam int OP_W   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic tag_we = 1'b0;
  logic [4:0] tag_waddr = '0;
  logic tag_wvec = 1'b0;
  logic [6:0] tag_wtarget = '0;
  logic [1:0] tag_wew = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [OP_W-1:0] in_opcode = '0;
  logic [4:0] in_rd = '0, in_rs1 = '0, in_rs2 = '0;
  logic [4:0] in_vlen = '0;
  logic [MAX_VL-1:0] in_pred = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [OP_W-1:0] out_opcode;
  logic [3:0] out_elem;
  logic [6:0] out_rd, out_rs1, out_rs2;
  logic [2:0] out_rd_off, out_rs1_off, out_rs2_off;
  logic [1:0] out_rd_ew, out_rs1_ew, out_rs2_ew;

  always #2.5 clk = ~clk;

  vec_elem_seq #(.MAX_VL(MAX_VL), .OP_W(OP_W)) i_vec_elem_seq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .tag_we(tag_we), .tag_waddr(tag_waddr), .tag_wvec(tag_wvec),
    .tag_wtarget(tag_wtarget), .tag_wew(tag_wew),
    .in_valid(in_valid), .in_ready(in_ready), .in_opcode(in_opcode),
    .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2),
    .in_vlen(in_vlen), .in_pred(in_pred),
    .out_valid(out_valid), .out_ready(out_ready), .out_opcode(out_opcode),
    .out_elem(out_elem),
    .out_rd(out_rd), .out_rd_off(out_rd_off), .out_rd_ew(out_rd_ew),
    .out_rs1(out_rs1), .out_rs1_off(out_rs1_off), .out_rs1_ew(out_rs1_ew),
    .out_rs2(out_rs2), .out_rs2_off(out_rs2_off), .out_rs2_ew(out_rs2_ew)
  );

  int checks = 0;
  int errors = 0;
  bit sh_vec [32];
  int sh_tgt [32];
  int sh_ew  [32];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  task automatic write_tag(input int a, input bit v, input int t, input int e);
    @(negedge clk);
    tag_we = 1'b1; tag_waddr = 5'(a); tag_wvec = v;
    tag_wtarget = 7'(t); tag_wew = 2'(e);
    sh_vec[a] = v; sh_tgt[a] = t; sh_ew[a] = e;
    @(negedge clk);
    tag_we = 1'b0;
  endtask

  // Expected location of one operand for element i, from R4/R5/R7
  task automatic exp_loc(input int a, input int i, output int r, output int o, output int e);
    int w;
    if (sh_vec[a]) begin
      w = 64 >> sh_ew[a];
      r = (sh_tgt[a] + (i * w) / 64) % 128;
      o = ((i * w) % 64) / 8;
      e = sh_ew[a];
    end else begin
      r = a; o = 0; e = 0;
    end
  endtask

  task automatic check_op(input string req, input int a_rd, input int a_rs1,
                          input int a_rs2, input int op, input int i);
    int r, o, e;
    chk(out_elem == 4'(i), req, "elem", out_elem, i);
    chk(out_opcode == 8'(op), req, "opcode", out_opcode, op);
    exp_loc(a_rd, i, r, o, e);
    chk(out_rd == 7'(r), req, "rd", out_rd, r);
    chk(out_rd_off == 3'(o), req, "rd_off", out_rd_off, o);
    chk(out_rd_ew == 2'(e), req, "rd_ew", out_rd_ew, e);
    exp_loc(a_rs1, i, r, o, e);
    chk(out_rs1 == 7'(r), req, "rs1", out_rs1, r);
    chk(out_rs1_off == 3'(o), req, "rs1_off", out_rs1_off, o);
    chk(out_rs1_ew == 2'(e), req, "rs1_ew", out_rs1_ew, e);
    exp_loc(a_rs2, i, r, o, e);
    chk(out_rs2 == 7'(r), req, "rs2", out_rs2, r);
    chk(out_rs2_off == 3'(o), req, "rs2_off", out_rs2_off, o);
    chk(out_rs2_ew == 2'(e), req, "rs2_ew", out_rs2_ew, e);
  endtask

  // Issue one instruction and collect all emitted operations.
  // rdy_mode: 0 always ready, 1 alternating, 2 ready every third cycle.
  task automatic run_instr(input string req, input int op, input int rd,
                           input int rs1, input int rs2, input int vlen,
                           input logic [15:0] pred, input int rdy_mode);
    int exp_idx [16];
    int exp_n = 0;
    int got = 0;
    bit hold = 0;
    int h_elem = 0, h_rd = 0, h_rs1 = 0, h_rs2 = 0;
    if (!(sh_vec[rd] || sh_vec[rs1] || sh_vec[rs2])) begin
      exp_idx[0] = 0; exp_n = 1;
    end else begin
      for (int i = 0; i < vlen; i++)
        if (pred[i]) begin exp_idx[exp_n] = i; exp_n++; end
    end
    @(negedge clk);
    in_opcode = 8'(op); in_rd = 5'(rd); in_rs1 = 5'(rs1); in_rs2 = 5'(rs2);
    in_vlen = 5'(vlen); in_pred = pred; in_valid = 1'b1;
    #1;
    chk(in_ready == 1'b1, req, "in_ready before issue", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    for (int cyc = 0; cyc < 80; cyc++) begin
      case (rdy_mode)
        0: out_ready = 1'b1;
        1: out_ready = (cyc % 2) == 1;
        default: out_ready = (cyc % 3) == 2;
      endcase
      #1;
      if (hold) begin
        // R10 output fields held under back-pressure
        chk(out_valid && out_elem == 4'(h_elem) && out_rd == 7'(h_rd)
            && out_rs1 == 7'(h_rs1) && out_rs2 == 7'(h_rs2),
            "R10", "held elem", out_elem, h_elem);
      end
      if (out_valid) begin
        chk(in_ready == 1'b0, "R10", "in_ready while emitting", in_ready, 0);
      end
      hold = out_valid && !out_ready;
      h_elem = out_elem; h_rd = out_rd; h_rs1 = out_rs1; h_rs2 = out_rs2;
      if (out_valid && out_ready) begin
        if (got < exp_n) check_op(req, rd, rs1, rs2, op, exp_idx[got]);
        got++;
      end
      if (in_ready) break;
      @(negedge clk);
    end
    chk(got == exp_n, req, "operation count", got, exp_n);
    chk(in_ready == 1'b1, req, "in_ready after instruction", in_ready, 1);
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
  endtask

  task automatic t_dest_vector();
    write_tag(5, 1, 40, 1);  // 32-bit elements at 40
    run_instr("R2 R4 R5 R7", 8'h21, 5, 7, 9, 5, 16'hffff, 0);
  endtask

  task automatic t_sparse_mix();
    write_tag(10, 1, 20, 2);  // 16-bit
    write_tag(11, 1, 60, 3);  // 8-bit
    write_tag(12, 1, 90, 0);  // 64-bit
    run_instr("R3 R5 R10", 8'h33, 10, 11, 12, 8, 16'b0000_0000_1011_0101, 1);
  endtask

  task automatic t_shared_target();
    write_tag(3, 1, 126, 3);  // 8-bit
    write_tag(4, 1, 126, 1);  // 32-bit, wraps past 127
    run_instr("R6 R4", 8'h44, 9, 3, 4, 16, 16'hffff, 2);
  endtask

  task automatic t_passthrough();
    run_instr("R8", 8'h55, 1, 2, 6, 7, 16'h0000, 0);
    run_instr("R8 R7", 8'h56, 13, 14, 15, 0, 16'h00ff, 1);
  endtask

  task automatic t_empty();
    run_instr("R9 vlen zero", 8'h61, 5, 0, 0, 0, 16'hffff, 0);
    run_instr("R9 mask zero", 8'h62, 5, 0, 0, 5, 16'hffe0, 0);
  endtask

  task automatic t_flush();
    @(negedge clk);
    in_opcode = 8'h70; in_rd = 5'd5; in_rs1 = 5'd0; in_rs2 = 5'd0;
    in_vlen = 5'd8; in_pred = 16'hffff; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (2) @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0; out_ready = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R11", "out_valid after flush", out_valid, 0);
    chk(in_ready == 1'b1, "R11", "in_ready after flush", in_ready, 1);
    repeat (3) begin
      @(negedge clk);
      #1;
      chk(out_valid == 1'b0, "R11", "no ops from dropped instr", out_valid, 0);
    end
    out_ready = 1'b0;
    run_instr("R11 recovery", 8'h71, 5, 0, 0, 3, 16'h0007, 0);
  endtask

  initial begin
    for (int k = 0; k < 32; k++) begin
      sh_vec[k] = 0; sh_tgt[k] = 0; sh_ew[k] = 0;
    end
    t_reset();
    t_dest_vector();
    t_sparse_mix();
    t_shared_target();
    write_tag(5, 0, 0, 0);
    t_passthrough();
    write_tag(5, 1, 100, 2);
    t_empty();
    t_flush();
    summary();
    $finish;
  end
endmodule